// File: doc/BRIEF.md
# Serial Flash Command Frame Decoder

This block is the receive front end of a serial flash slave. It oversamples the chip select, serial clock and serial data pins with the core clock. It frames each command on the active-low select and picks the clock mode from the idle clock level seen at select time. It shifts in an opcode, then a 24-bit address, then however many filler bytes that opcode calls for. It then presents the opcode, page number and byte offset to a downstream sequencer as a one-cycle command pulse.

After the command pulse the frame enters a data phase. For read-class opcodes the block pulls bytes from a valid/ready source and shifts them out MSB first, changing the output on falling serial-clock edges. For all other opcodes each further received byte appears on a one-cycle write strobe. The serial side cannot be stalled. On the read side the source is asked for a byte early, through a one-byte holding register. On the write side the sink has no ready and must take every strobe.

The read source follows valid/ready. A byte moves when `rd_valid` and `rd_ready` are both high on a clock edge. `rd_ready` is high only during a read data phase while the holding register is empty. If the source lets the register run dry, all-ones are shifted out.

Top module: `spi_cmd_decoder`

## Requirements
- R1: While chip select is high, serial clock and data activity produces no command and no write strobe. `so_oe` is low within one core cycle after the synchronised select goes high.
- R2: `mode_hi` is 1 after reset. On every select falling edge it takes the serial clock level: 1 means idle-high (mode 3) and 0 means idle-low (mode 0). It holds for the rest of the frame.
- R3: Data is sampled on rising serial-clock edges, MSB first. Of the 24 address bits, the top 5 are ignored. Bits 18..9 give `cmd_page` and bits 8..0 give `cmd_byte`.
- R4: Buffer-only opcodes (84h, 87h, 54h, 56h, D4h, D6h) report `cmd_page` = 0 whatever page bits were sent.
- R5: The header after the opcode is 7 bytes for 52h, 68h, D2h and E8h. It is 4 bytes for 54h, 56h, D4h and D6h, 0 bytes for 57h and D7h, and 3 bytes otherwise. Filler bytes never change the reported fields.
- R6: Status opcodes 57h and D7h raise `cmd_valid` right after the opcode byte, with page and byte both 0.
- R7: `cmd_valid` is a single-cycle pulse, raised once per frame only after the last header byte. It is never raised before that.
- R8: A frame whose select rises before the header is complete produces no command. The next frame decodes normally.
- R9: For read-class opcodes (52h, 68h, D2h, E8h, 54h, 56h, D4h, D6h, 57h, D7h), `so_oe` is high in the data phase. Source bytes go out MSB first and in source order. A new bit appears after each falling serial-clock edge.
- R10: If no source byte is held when a new output byte starts, the byte shifted out is FFh.
- R11: For other opcodes, every complete byte received after the header raises `wr_valid` for one cycle with that byte on `wr_data`, in arrival order. `so_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the `so` pad driver |
| mode_hi | output | 1 | Detected clock mode, 1 = idle-high |
| rd_data | input | 8 | Read source byte |
| rd_valid | input | 1 | Read source byte available |
| rd_ready | output | 1 | Holding register can take a byte |
| cmd_valid | output | 1 | One-cycle decoded command pulse |
| cmd_opcode | output | 8 | Decoded opcode |
| cmd_page | output | 10 | Page number field |
| cmd_byte | output | 9 | Byte offset field |
| wr_data | output | 8 | Received data-phase byte |
| wr_valid | output | 1 | One-cycle strobe for `wr_data` |

## Verification
If the header byte counter lands on the wrong value, `cmd_valid` shows up one byte early or late. The check that no pulse appears after the second-to-last header byte catches the early case within eight serial clocks. A misplaced address shift or a missed bit lands in `cmd_page` or `cmd_byte` at that same pulse. A holding register or output bit counter out of step corrupts the very first read-out byte, either as a shifted pattern or as a spurious FFh. A phase register left set after deselect keeps `so_oe` high for more than one core cycle, which is visible at once.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int RSV_W  = 5;
  localparam int PAGE_W = 10;
  localparam int BYTE_W = 9;
  localparam int ADDR_W = RSV_W + PAGE_W + BYTE_W;
  localparam int KEEP_W = PAGE_W + BYTE_W;
  localparam logic [2:0] ADDR_BYTES = 3'(ADDR_W / 8);

  typedef enum logic [1:0] {PH_IDLE, PH_OPC, PH_HDR, PH_DATA} phase_t;

  function automatic logic [2:0] hdr_bytes(input logic [7:0] op);
    case (op)
      8'h57, 8'hD7:               return 3'd0;
      8'h52, 8'h68, 8'hD2, 8'hE8: return ADDR_BYTES + 3'd4;
      8'h54, 8'h56, 8'hD4, 8'hD6: return ADDR_BYTES + 3'd1;
      default:                    return ADDR_BYTES;
    endcase
  endfunction

  function automatic logic is_status(input logic [7:0] op);
    return (op == 8'h57) || (op == 8'hD7);
  endfunction

  function automatic logic is_buf_only(input logic [7:0] op);
    case (op)
      8'h84, 8'h87, 8'h54, 8'h56, 8'hD4, 8'hD6: return 1'b1;
      default:                                  return 1'b0;
    endcase
  endfunction

  function automatic logic is_read(input logic [7:0] op);
    case (op)
      8'h52, 8'h68, 8'hD2, 8'hE8,
      8'h54, 8'h56, 8'hD4, 8'hD6,
      8'h57, 8'hD7:               return 1'b1;
      default:                    return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES+1];

  assign chain[0] = d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g+1] <= RST_VAL;
      else        chain[g+1] <= chain[g];
    end
  end

  assign q = chain[STAGES];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sel_fall,
  input  logic              sck_lvl,
  input  logic              sck_rise,
  input  logic              si_lvl,
  output logic              mode_hi,
  output logic              cmd_valid,
  output logic [7:0]        cmd_opcode,
  output logic [PAGE_W-1:0] cmd_page,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              wr_valid,
  output logic [7:0]        wr_data,
  output logic              rd_phase
);
  phase_t            phase;
  logic [6:0]        sh;
  logic [2:0]        bit_cnt;
  logic [2:0]        hdr_cnt;
  logic [7:0]        op_r;
  logic [KEEP_W-1:0] addr;
  logic              rd_cls;

  logic [7:0]        byte_in;
  logic [7:0]        op_cur;
  logic [KEEP_W-1:0] addr_cur;
  logic              hdr_done;

  assign byte_in = {sh, si_lvl};

  always_comb begin
    op_cur   = (phase == PH_OPC) ? byte_in : op_r;
    addr_cur = addr;
    hdr_done = 1'b0;
    if (phase == PH_OPC) begin
      addr_cur = '0;
      hdr_done = (hdr_bytes(byte_in) == 3'd0);
    end else if (phase == PH_HDR) begin
      if (hdr_cnt < ADDR_BYTES) addr_cur = {addr[KEEP_W-9:0], byte_in};
      hdr_done = ((hdr_cnt + 3'd1) == hdr_bytes(op_r));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      mode_hi    <= 1'b1;
      sh         <= '0;
      bit_cnt    <= '0;
      hdr_cnt    <= '0;
      op_r       <= '0;
      addr       <= '0;
      rd_cls     <= 1'b0;
      cmd_valid  <= 1'b0;
      cmd_opcode <= '0;
      cmd_page   <= '0;
      cmd_byte   <= '0;
      wr_valid   <= 1'b0;
      wr_data    <= '0;
    end else begin
      cmd_valid <= 1'b0;
      wr_valid  <= 1'b0;
      if (sel_fall) begin
        mode_hi <= sck_lvl;
        phase   <= PH_OPC;
        bit_cnt <= '0;
        hdr_cnt <= '0;
        rd_cls  <= 1'b0;
      end else if (!sel) begin
        phase <= PH_IDLE;
      end else if (sck_rise && phase != PH_IDLE) begin
        sh      <= byte_in[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          case (phase)
            PH_OPC: begin
              op_r  <= byte_in;
              phase <= PH_HDR;
            end
            PH_HDR: begin
              addr    <= addr_cur;
              hdr_cnt <= hdr_cnt + 3'd1;
            end
            PH_DATA: begin
              if (!rd_cls) begin
                wr_valid <= 1'b1;
                wr_data  <= byte_in;
              end
            end
            default: ;
          endcase
          if (hdr_done) begin
            phase      <= PH_DATA;
            rd_cls     <= is_read(op_cur);
            cmd_valid  <= 1'b1;
            cmd_opcode <= op_cur;
            cmd_page   <= (is_buf_only(op_cur) || is_status(op_cur)) ? '0
                          : addr_cur[KEEP_W-1:BYTE_W];
            cmd_byte   <= is_status(op_cur) ? '0 : addr_cur[BYTE_W-1:0];
          end
        end
      end
    end
  end

  assign rd_phase = (phase == PH_DATA) && rd_cls;
endmodule

// File: rtl/spi_tx_stream.sv
module spi_tx_stream (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_phase,
  input  logic       sck_fall,
  input  logic [7:0] rd_data,
  input  logic       rd_valid,
  output logic       rd_ready,
  output logic       so,
  output logic       so_oe
);
  logic [7:0] hold;
  logic       hold_full;
  logic [7:0] tx_sh;
  logic [2:0] out_cnt;

  assign rd_ready = rd_phase && !hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
      tx_sh     <= '1;
      out_cnt   <= '0;
    end else if (!rd_phase) begin
      hold_full <= 1'b0;
      tx_sh     <= '1;
      out_cnt   <= '0;
    end else begin
      if (sck_fall) begin
        if (out_cnt == 3'd0) begin
          tx_sh     <= hold_full ? hold : 8'hFF;
          hold_full <= 1'b0;
        end else begin
          tx_sh <= {tx_sh[6:0], 1'b1};
        end
        out_cnt <= out_cnt + 3'd1;
      end
      if (rd_valid && rd_ready) begin
        hold      <= rd_data;
        hold_full <= 1'b1;
      end
    end
  end

  assign so    = tx_sh[7];
  assign so_oe = rd_phase;
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  output logic              mode_hi,
  input  logic [7:0]        rd_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  output logic              cmd_valid,
  output logic [7:0]        cmd_opcode,
  output logic [PAGE_W-1:0] cmd_page,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic [7:0]        wr_data,
  output logic              wr_valid
);
  logic [2:0] pins_s;
  logic       cs_n_s, sck_s, si_s;
  logic       cs_n_d, sck_d;
  logic       sel_s, sel_fall, sck_rise, sck_fall;
  logic       rd_phase;

  spi_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sck, si}), .q(pins_s)
  );

  assign {cs_n_s, sck_s, si_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_d <= 1'b1;
      sck_d  <= 1'b1;
    end else begin
      cs_n_d <= cs_n_s;
      sck_d  <= sck_s;
    end
  end

  assign sel_s    = !cs_n_s;
  assign sel_fall = cs_n_d && !cs_n_s;
  assign sck_rise = !sck_d && sck_s;
  assign sck_fall = sck_d && !sck_s;

  spi_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sel(sel_s), .sel_fall(sel_fall),
    .sck_lvl(sck_s), .sck_rise(sck_rise), .si_lvl(si_s),
    .mode_hi(mode_hi), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
    .cmd_page(cmd_page), .cmd_byte(cmd_byte),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_phase(rd_phase)
  );

  spi_tx_stream u_tx (
    .clk(clk), .rst_n(rst_n), .rd_phase(rd_phase), .sck_fall(sck_fall),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .so(so), .so_oe(so_oe)
  );
endmodule

// File: rtl/spi_cmd_decoder_chk.sv
module spi_cmd_decoder_chk
  import spi_cmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sel_s,
  input logic              so_oe,
  input logic              mode_hi,
  input logic              cmd_valid,
  input logic [7:0]        cmd_opcode,
  input logic [PAGE_W-1:0] cmd_page,
  input logic [BYTE_W-1:0] cmd_byte,
  input logic              wr_valid
);
  assert_oe_off_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s |=> !so_oe);

  assert_mode_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s && $past(sel_s) |=> $stable(mode_hi));

  assert_buf_page_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && is_buf_only(cmd_opcode) |-> cmd_page == '0);

  assert_status_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && is_status(cmd_opcode) |-> (cmd_page == '0) && (cmd_byte == '0));

  assert_cmd_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_wr_no_oe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !so_oe);
endmodule

bind spi_cmd_decoder spi_cmd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .so_oe(so_oe), .mode_hi(mode_hi),
  .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_page(cmd_page),
  .cmd_byte(cmd_byte), .wr_valid(wr_valid)
);

// File: tb/spi_cmd_decoder_tb.sv
module spi_cmd_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;
  localparam int NVEC = 8;

  // {mode, opcode, addr[23:0], header bytes, exp page, exp byte}
  localparam logic [54:0] VEC [NVEC] = '{
    {1'b1, 8'h83, 5'h15, 10'h2A5, 9'h0F3, 3'd3, 10'h2A5, 9'h0F3},
    {1'b1, 8'h84, 5'h1F, 10'h3FF, 9'h155, 3'd3, 10'h000, 9'h155},
    {1'b0, 8'h52, 5'h00, 10'h155, 9'h1AA, 3'd7, 10'h155, 9'h1AA},
    {1'b0, 8'h54, 5'h00, 10'h2AB, 9'h033, 3'd4, 10'h000, 9'h033},
    {1'b1, 8'h57, 5'h00, 10'h000, 9'h000, 3'd0, 10'h000, 9'h000},
    {1'b0, 8'hD7, 5'h00, 10'h000, 9'h000, 3'd0, 10'h000, 9'h000},
    {1'b0, 8'h81, 5'h00, 10'h001, 9'h100, 3'd3, 10'h001, 9'h100},
    {1'b1, 8'hE8, 5'h03, 10'h200, 9'h001, 3'd7, 10'h200, 9'h001}
  };

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 1, si = 0, rd_valid = 1;
  logic [7:0] rd_data, rd_idx;
  logic so, so_oe, mode_hi, rd_ready, cmd_valid, wr_valid;
  logic [7:0] cmd_opcode, wr_data;
  logic [9:0] cmd_page;
  logic [8:0] cmd_byte;

  int nchk = 0, nerr = 0, ncmd = 0, nwr = 0;
  logic [7:0] cap_op, wr_got [8];
  logic [9:0] cap_page;
  logic [8:0] cap_byte;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so),
    .so_oe(so_oe), .mode_hi(mode_hi), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
    .cmd_page(cmd_page), .cmd_byte(cmd_byte), .wr_data(wr_data),
    .wr_valid(wr_valid)
  );

  assign rd_data = 8'hA5 + rd_idx * 8'h37;

  always @(posedge clk) begin
    if (!rst_n) rd_idx <= 0;
    else if (rd_valid && rd_ready) rd_idx <= rd_idx + 1;
    if (cmd_valid) begin
      ncmd <= ncmd + 1; cap_op <= cmd_opcode; cap_page <= cmd_page; cap_byte <= cmd_byte;
    end
    if (wr_valid) begin
      wr_got[nwr[2:0]] <= wr_data; nwr <= nwr + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe_any);
    oe_any = 0;
    for (int i = 7; i >= 0; i--) begin
      sck = 0; si = tx[i];
      wait_h();
      rx[i] = so; oe_any = oe_any | so_oe;
      sck = 1;
      wait_h();
    end
  endtask

  task automatic start_frame(input logic m3);
    sck = m3; wait_h();
    cs_n = 0; wait_h();
  endtask

  task automatic end_frame(input logic m3);
    if (!m3) begin sck = 0; wait_h(); end
    cs_n = 1; wait_h(); wait_h();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] rx, base;
    logic oe;
    int c0, w0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // reset state
    check("R2 reset mode_hi", mode_hi, 1);
    check("R1 reset so_oe", so_oe, 0);
    check("R7 reset cmd_valid", cmd_valid, 0);
    check("R9 reset rd_ready", rd_ready, 0);

    // R1: activity while deselected
    xfer(8'h57, rx, oe);
    xfer(8'h84, rx, oe);
    wait_h();
    check("R1 no cmd while deselected", ncmd, 0);
    check("R1 no wr while deselected", nwr, 0);
    check("R1 so_oe low while deselected", oe, 0);

    // table-driven frames: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      logic m3; logic [7:0] op; logic [23:0] ad; logic [2:0] nh;
      m3 = VEC[v][54]; op = VEC[v][53:46]; ad = VEC[v][45:22]; nh = VEC[v][21:19];
      c0 = ncmd;
      start_frame(m3);
      xfer(op, rx, oe);
      for (int b = 0; b < int'(nh); b++) begin
        logic [7:0] tb_byte;
        tb_byte = (b == 0) ? ad[23:16] : (b == 1) ? ad[15:8] : (b == 2) ? ad[7:0] : 8'hC3;
        if (b == int'(nh) - 1) check("R5 R7 no early cmd_valid", ncmd - c0, 0);
        xfer(tb_byte, rx, oe);
      end
      check("R7 one cmd per frame", ncmd - c0, 1);
      check("R3 opcode", cap_op, op);
      check("R3 R4 R6 page field", cap_page, VEC[v][18:9]);
      check("R3 R6 byte field", cap_byte, VEC[v][8:0]);
      check("R2 mode detect", mode_hi, m3);
      end_frame(m3);
      check("R2 mode held after frame", mode_hi, m3);
    end

    // R8: aborted frame, then recovery
    c0 = ncmd;
    start_frame(1);
    xfer(8'h83, rx, oe); xfer(8'h01, rx, oe); xfer(8'h02, rx, oe);
    end_frame(1);
    check("R8 aborted frame discarded", ncmd - c0, 0);
    start_frame(1);
    xfer(8'hD7, rx, oe);
    end_frame(1);
    check("R8 next frame decodes", ncmd - c0, 1);
    check("R8 next frame opcode", cap_op, 8'hD7);

    // R9: read stream, mode 3, 7-byte header
    start_frame(1);
    xfer(8'hD2, rx, oe);
    for (int b = 0; b < 7; b++) xfer(8'h11, rx, oe);
    base = rd_idx - 1;
    for (int k = 0; k < 3; k++) begin
      logic [7:0] ex;
      ex = 8'hA5 + (base + 8'(k)) * 8'h37;
      xfer(8'h00, rx, oe);
      check("R9 read byte order MSB first", rx, ex);
      check("R9 so_oe in read phase", oe, 1);
    end
    end_frame(1);
    check("R1 so_oe low after deselect", so_oe, 0);

    // R10: underrun yields FFh, mode 0
    rd_valid = 0;
    start_frame(0);
    xfer(8'h57, rx, oe);
    check("R9 rd_ready while empty", rd_ready, 1);
    xfer(8'h00, rx, oe);
    check("R10 underrun byte", rx, 8'hFF);
    end_frame(0);
    rd_valid = 1;

    // R11: write data strobes
    w0 = nwr;
    start_frame(0);
    xfer(8'h84, rx, oe);
    xfer(8'h00, rx, oe); xfer(8'h00, rx, oe); xfer(8'h07, rx, oe);
    xfer(8'h96, rx, oe);
    check("R11 so_oe low in write phase", oe, 0);
    xfer(8'h0F, rx, oe);
    end_frame(0);
    check("R11 write strobe count", nwr - w0, 2);
    check("R11 first write byte", wr_got[w0[2:0]], 8'h96);
    check("R11 second write byte", wr_got[3'(w0 + 1)], 8'h0F);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule